// File: doc/BRIEF.md
# I2C Byte-Transfer Master

This block is a bus master for a two-wire serial bus that moves one byte per command. Software first loads an 8-bit data buffer and sets qualifier bits in a small control register, then sets a launch bit. The engine then clocks one byte over SCL/SDA. That byte may be preceded by a START (or a repeated START) and may be followed by a STOP. While the byte is in flight the launch bit reads back as 1, and it clears itself once the acknowledge bit is done.

After an address byte, the least significant bit of the buffer picks the direction. When it is 0 the engine keeps transmitting, and when it is 1 it receives. In receive mode each byte is clocked into the buffer, and the master answers with ACK or NAK according to a control bit. Both bus lines are open-drain: the block only ever pulls a line low or releases it. It reads the real line levels back, which lets it check that the bus is free before a START and detect lost arbitration. A programmable divider sets the bit rate, and every bit is split into four quarter phases.

Top module: `i2c_byte_master`

## Requirements
- R1: Nothing happens on the bus until a control write sets the launch bit (control bit 0). The launch bit reads back as 1 while the byte is in progress and clears itself when the byte, its acknowledge and any STOP are done. If a byte is launched without a START while the bus is not held, it completes with no bus activity.
- R2: The qualifier bits are control bit 1 (start) and control bit 2 (stop). With both clear, a bare byte is sent. With start set and stop clear, a START goes out first and then the buffer byte. With stop set, the byte goes out and a STOP follows, and the start bit is ignored.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Data bits go out MSB first, and the line is valid while SCL is high.
- R4: At the end of an address byte (a byte sent with a START), receive mode is set equal to buffer bit 0.
- R5: A START requested while the bus is held produces a repeated START with no STOP in between, and carries the new address and direction.
- R6: The engine never alters the start, stop or NAK control bits. Only a control write changes them.
- R7: A START from the released state waits until both lines are high. If SDA is low when the START is checked, the attempt is retried and the bus is not driven in the meantime.
- R8: In receive mode the byte is clocked into the buffer. The master drives the acknowledge bit from control bit 3 (0 = ACK, 1 = NAK), and a STOP follows when stop is set.
- R9: In transmit mode the status output ack_ok is 1 when the slave pulled SDA low in the acknowledge bit and 0 when it did not.
- R10: If a 1 is being sent and SDA is sampled low, arb_lost is set, both lines are released, bus_owned drops and the launch bit clears. arb_lost is cleared by the next launch.
- R11: Each quarter phase lasts q_div+1 clocks, and SCL is high for two quarters of every bit.
- R12: Buffer writes made while the launch bit is set are ignored.
- R13: When the engine is idle and does not hold the bus, both lines are released. When it is idle and holds the bus, SCL is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| q_div | input | DIV_W | Quarter-phase length minus one, in clocks |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | {nak, stop, start, launch} |
| ctl_rdata | output | 4 | Control register readback; bit 0 is the busy launch bit |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | BYTE_W | Data buffer write value |
| buf_rdata | output | BYTE_W | Data buffer contents |
| ack_ok | output | 1 | Slave acknowledged the last transmitted byte |
| arb_lost | output | 1 | Arbitration lost during the last launch |
| rx_mode | output | 1 | Engine is in receive mode |
| bus_owned | output | 1 | Engine holds the bus between START and STOP |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_lo | output | 1 | Pull SCL low |
| sda_lo | output | 1 | Pull SDA low |

## Verification
Some properties are checked on every cycle. These are that the lines are released whenever the engine is idle and not holding the bus, that SCL stays low between bytes while the bus is held, that only a control write can start a transfer, that the qualifier bits change only through a write, and that the buffer is locked while a transmit is in progress. The scenarios must show the properties that depend on the shape of the bus waveform: START and STOP placement, repeated START, direction switching, ACK and NAK in both modes, bit timing, waiting for a free bus, and arbitration loss. A modelled slave and a second driver that pulls the line low provide this evidence.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  localparam int CTL_W     = 4;
  localparam int CTL_XFER  = 0;
  localparam int CTL_START = 1;
  localparam int CTL_STOP  = 2;
  localparam int CTL_NAK   = 3;

  typedef enum logic [1:0] {BC_START, BC_BIT, BC_STOP} bus_cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FREE, SQ_START, SQ_BITS, SQ_ACK, SQ_STOP
  } seq_st_e;
endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = !restart && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || restart || cnt == div) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] q_div,
  input  logic             cmd_valid,
  input  bus_cmd_e         cmd,
  input  logic             tx_bit,
  input  logic             chk_arb,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             active,
  output logic             done,
  output logic             lost,
  output logic             rx_bit,
  output logic             scl_lo,
  output logic             sda_lo
);
  logic     accept, tick;
  logic [1:0] ph;
  bus_cmd_e cmd_q;
  logic     bit_q, chk_q;

  assign accept = cmd_valid && !active;

  i2c_qtick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .restart(accept), .div(q_div), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; ph <= 2'd0; cmd_q <= BC_BIT; bit_q <= 1'b1; chk_q <= 1'b0;
      done <= 1'b0; lost <= 1'b0; rx_bit <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      if (accept) begin
        active <= 1'b1; ph <= 2'd0; cmd_q <= cmd; bit_q <= tx_bit; chk_q <= chk_arb;
        case (cmd)
          BC_START: sda_lo <= 1'b0;
          BC_BIT:   begin scl_lo <= 1'b1; sda_lo <= ~tx_bit; end
          default:  begin scl_lo <= 1'b1; sda_lo <= 1'b1; end
        endcase
      end else if (active && tick) begin
        if (ph == 2'd3) begin
          active <= 1'b0; done <= 1'b1;
        end else if (ph == 2'd1 && cmd_q == BC_START && !(sda_i && scl_i)) begin
          active <= 1'b0; done <= 1'b1; lost <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
        end else if (ph == 2'd2 && cmd_q == BC_BIT && chk_q && bit_q && !sda_i) begin
          rx_bit <= sda_i;
          active <= 1'b0; done <= 1'b1; lost <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
        end else begin
          ph <= ph + 2'd1;
          case (ph)
            2'd0: scl_lo <= 1'b0;
            2'd1: begin
              if (cmd_q == BC_START)     sda_lo <= 1'b1;
              else if (cmd_q == BC_STOP) sda_lo <= 1'b0;
            end
            default: begin
              rx_bit <= sda_i;
              if (cmd_q != BC_STOP) scl_lo <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq
  import i2c_bm_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              want_start,
  input  logic              want_stop,
  input  logic              want_nak,
  input  logic [BYTE_W-1:0] buf_q,
  input  logic              eng_active,
  input  logic              eng_done,
  input  logic              eng_lost,
  input  logic              eng_rx_bit,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              cmd_valid,
  output bus_cmd_e          cmd,
  output logic              cmd_bit,
  output logic              cmd_chk,
  output logic              xfer_done,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              ack_ok,
  output logic              arb_lost,
  output logic              rx_mode,
  output logic              owned
);
  localparam int CNT_W = $clog2(BYTE_W);

  seq_st_e     st;
  logic [CNT_W-1:0] bitn;
  logic        addr_q, stop_q, nak_q, tx_q;
  logic        start_req;

  assign start_req = want_start && !want_stop;

  always_comb begin
    cmd_valid = (st == SQ_START || st == SQ_BITS || st == SQ_ACK || st == SQ_STOP)
                && !eng_active && !eng_done;
    cmd     = BC_BIT;
    cmd_bit = 1'b1;
    cmd_chk = 1'b0;
    case (st)
      SQ_START: cmd = BC_START;
      SQ_STOP:  cmd = BC_STOP;
      SQ_BITS:  begin cmd_bit = tx_q ? rx_byte[BYTE_W-1] : 1'b1; cmd_chk = tx_q; end
      SQ_ACK:   cmd_bit = tx_q ? 1'b1 : nak_q;
      default:  cmd = BC_BIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= SQ_IDLE; bitn <= '0; addr_q <= 1'b0; stop_q <= 1'b0; nak_q <= 1'b0;
      tx_q <= 1'b1; rx_byte <= '0; xfer_done <= 1'b0; rx_load <= 1'b0;
      ack_ok <= 1'b0; arb_lost <= 1'b0; rx_mode <= 1'b0; owned <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      rx_load   <= 1'b0;
      case (st)
        SQ_IDLE: if (go && !xfer_done) begin
          if (!start_req && !owned) begin
            xfer_done <= 1'b1;
          end else begin
            rx_byte  <= buf_q;
            bitn     <= '0;
            arb_lost <= 1'b0;
            addr_q   <= start_req;
            stop_q   <= want_stop;
            nak_q    <= want_nak;
            tx_q     <= start_req || !rx_mode;
            if (start_req) st <= owned ? SQ_START : SQ_FREE;
            else           st <= SQ_BITS;
          end
        end
        SQ_FREE: if (scl_i && sda_i) st <= SQ_START;
        SQ_START: if (eng_done) begin
          if (eng_lost) begin arb_lost <= 1'b1; owned <= 1'b0; st <= SQ_FREE; end
          else          begin owned <= 1'b1; st <= SQ_BITS; end
        end
        SQ_BITS: if (eng_done) begin
          if (eng_lost) begin
            arb_lost <= 1'b1; owned <= 1'b0; st <= SQ_IDLE; xfer_done <= 1'b1;
          end else begin
            rx_byte <= {rx_byte[BYTE_W-2:0], eng_rx_bit};
            bitn    <= bitn + 1'b1;
            if (bitn == CNT_W'(BYTE_W-1)) st <= SQ_ACK;
          end
        end
        SQ_ACK: if (eng_done) begin
          if (tx_q) ack_ok  <= !eng_rx_bit;
          else      rx_load <= 1'b1;
          if (addr_q) rx_mode <= buf_q[0];
          addr_q <= 1'b0;
          if (stop_q) st <= SQ_STOP;
          else begin st <= SQ_IDLE; xfer_done <= 1'b1; end
        end
        SQ_STOP: if (eng_done) begin
          owned <= 1'b0; st <= SQ_IDLE; xfer_done <= 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  q_div,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic              buf_we,
  input  logic [BYTE_W-1:0] buf_wdata,
  output logic [BYTE_W-1:0] buf_rdata,
  output logic              ack_ok,
  output logic              arb_lost,
  output logic              rx_mode,
  output logic              bus_owned,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_lo,
  output logic              sda_lo
);
  logic xfer_q, start_q, stop_q, nak_q;
  logic [BYTE_W-1:0] buf_q;

  logic        cmd_valid, cmd_bit, cmd_chk, seq_done, rx_load;
  bus_cmd_e    cmd;
  logic [BYTE_W-1:0] rx_byte;
  logic        eng_active, eng_done, eng_lost, eng_rx_bit;

  assign ctl_rdata = {nak_q, stop_q, start_q, xfer_q};
  assign buf_rdata = buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0; nak_q <= 1'b0; buf_q <= '0;
    end else begin
      if (ctl_we) begin
        start_q <= ctl_wdata[CTL_START];
        stop_q  <= ctl_wdata[CTL_STOP];
        nak_q   <= ctl_wdata[CTL_NAK];
      end
      if (seq_done)                         xfer_q <= 1'b0;
      else if (ctl_we && ctl_wdata[CTL_XFER]) xfer_q <= 1'b1;
      if (rx_load)                 buf_q <= rx_byte;
      else if (buf_we && !xfer_q)  buf_q <= buf_wdata;
    end
  end

  i2c_byte_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .go(xfer_q), .want_start(start_q), .want_stop(stop_q),
    .want_nak(nak_q), .buf_q(buf_q), .eng_active(eng_active), .eng_done(eng_done),
    .eng_lost(eng_lost), .eng_rx_bit(eng_rx_bit), .scl_i(scl_i), .sda_i(sda_i),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_bit(cmd_bit), .cmd_chk(cmd_chk),
    .xfer_done(seq_done), .rx_load(rx_load), .rx_byte(rx_byte), .ack_ok(ack_ok),
    .arb_lost(arb_lost), .rx_mode(rx_mode), .owned(bus_owned)
  );

  i2c_bit_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .q_div(q_div), .cmd_valid(cmd_valid), .cmd(cmd),
    .tx_bit(cmd_bit), .chk_arb(cmd_chk), .scl_i(scl_i), .sda_i(sda_i),
    .active(eng_active), .done(eng_done), .lost(eng_lost), .rx_bit(eng_rx_bit),
    .scl_lo(scl_lo), .sda_lo(sda_lo)
  );
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic [3:0]        ctl_wdata,
  input logic [3:0]        ctl_rdata,
  input logic              buf_we,
  input logic [BYTE_W-1:0] buf_rdata,
  input logic              rx_mode,
  input logic              bus_owned,
  input logic              arb_lost,
  input logic              scl_lo,
  input logic              sda_lo
);
  // R13: released lines when idle and not holding the bus
  assert_idle_release_R13: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[0] && !bus_owned) |-> (!scl_lo && !sda_lo));

  // R13: SCL held low between bytes while the bus is held
  assert_hold_scl_R13: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[0] && bus_owned) |-> scl_lo);

  // R1: a transfer only begins after a control write with the launch bit
  assert_launch_by_write_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_rdata[0]) |-> $past(ctl_we && ctl_wdata[0]));

  // R6: qualifier bits change only through a control write
  assert_qualifier_kept_R6: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(ctl_rdata[3:1]));

  // R12: buffer locked during a transmit byte
  assert_buf_locked_R12: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[0] && !rx_mode && buf_we) |=> $stable(buf_rdata));

  // R10: arbitration loss is only raised while a transfer is running
  assert_arb_in_xfer_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> $past(ctl_rdata[0]));
endmodule

bind i2c_byte_master i2c_byte_master_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .buf_we(buf_we), .buf_rdata(buf_rdata), .rx_mode(rx_mode), .bus_owned(bus_owned),
  .arb_lost(arb_lost), .scl_lo(scl_lo), .sda_lo(sda_lo)
);

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb;
  localparam int DIV_W = 16;
  localparam logic [3:0] FX = 4'h1, FS = 4'h2, FP = 4'h4, FN = 4'h8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [DIV_W-1:0] q_div = 16'd3;
  logic       ctl_we = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  logic       buf_we = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_rdata;
  logic ack_ok, arb_lost, rx_mode, bus_owned, scl_lo, sda_lo;
  logic scl_line, sda_line;
  logic slv_lo = 1'b0, force_low = 1'b0, ack_en = 1'b1;

  assign scl_line = ~scl_lo;
  assign sda_line = ~(sda_lo | slv_lo | force_low);

  i2c_byte_master u_dut (
    .clk(clk), .rst(rst), .q_div(q_div), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
    .ack_ok(ack_ok), .arb_lost(arb_lost), .rx_mode(rx_mode), .bus_owned(bus_owned),
    .scl_i(scl_line), .sda_i(sda_line), .scl_lo(scl_lo), .sda_lo(sda_lo)
  );

  // slave model
  int bitcnt = 0, starts = 0, stops = 0;
  logic first = 1'b0, slv_tx = 1'b0, mack = 1'b1;
  logic [7:0] shreg = '0, addr_rx = '0, data_rx = '0, rd_byte = 8'hC7;

  always @(negedge sda_line) if (scl_line) begin
    starts++; bitcnt = 0; first = 1'b1; slv_tx = 1'b0; slv_lo = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) stops++;
  always @(posedge scl_line) begin
    if (bitcnt < 8) shreg = {shreg[6:0], sda_line};
    else            mack = sda_line;
    bitcnt++;
  end
  always @(negedge scl_line) begin
    if (bitcnt == 8) begin
      if (first) begin addr_rx = shreg; slv_tx = shreg[0]; slv_lo = ack_en; end
      else if (slv_tx) slv_lo = 1'b0;
      else begin data_rx = shreg; slv_lo = ack_en; end
    end else if (bitcnt == 9) begin
      bitcnt = 0; first = 1'b0;
      if (slv_tx && !mack) slv_lo = ~rd_byte[7];
      else slv_lo = 1'b0;
    end else if (bitcnt >= 1 && bitcnt < 8 && slv_tx && !first) begin
      slv_lo = ~rd_byte[7-bitcnt];
    end
  end

  // SCL high-time monitor
  int hcnt = 0, last_high = 0;
  always @(posedge clk) begin
    if (scl_line) hcnt <= hcnt + 1;
    else begin
      if (hcnt != 0) last_high <= hcnt;
      hcnt <= 0;
    end
  end

  int vecs = 0, errs = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [3:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic set_buf(input logic [7:0] v);
    @(negedge clk); buf_we = 1'b1; buf_wdata = v;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && ctl_rdata[0]; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input logic [3:0] flags);
    set_ctl(flags | FX);
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R13 scl released at reset", scl_line, 1);
    chk("R13 sda released at reset", sda_line, 1);
    chk("R1 busy clear at reset", ctl_rdata[0], 0);
    chk("R13 not owned at reset", bus_owned, 0);
  endtask

  task automatic t_launch_addr();
    int s0 = starts;
    set_buf(8'hA0);
    set_ctl(FS);
    repeat (60) @(negedge clk);
    chk("R1 no bus activity before launch", starts - s0, 0);
    chk("R1 scl idle before launch", scl_line, 1);
    set_ctl(FS | FX);
    chk("R1 busy after launch", ctl_rdata[0], 1);
    wait_idle();
    chk("R1 launch bit self-cleared", ctl_rdata[0], 0);
    chk("R2 start then address", addr_rx, 8'hA0);
    chk("R3 one START seen", starts - s0, 1);
    chk("R9 slave ack reported", ack_ok, 1);
    chk("R4 transmit after R/W=0", rx_mode, 0);
    chk("R6 start bit kept", ctl_rdata[1], 1);
    chk("R13 owned after start", bus_owned, 1);
    chk("R13 scl held low", scl_line, 0);
  endtask

  task automatic t_plain_write();
    int s0 = starts;
    set_buf(8'h3C);
    set_ctl(FX);
    repeat (40) @(negedge clk);
    set_buf(8'hFF);
    wait_idle();
    chk("R2 plain byte delivered", data_rx, 8'h3C);
    chk("R2 no START on plain byte", starts - s0, 0);
    chk("R12 buffer write ignored while busy", buf_rdata, 8'h3C);
    chk("R11 SCL high time", last_high, 2 * (int'(q_div) + 1));
  endtask

  task automatic t_write_stop();
    int s0 = starts, p0 = stops;
    set_buf(8'h5A);
    xfer(FP | FS);
    chk("R2 stop byte delivered", data_rx, 8'h5A);
    chk("R2 start ignored with stop", starts - s0, 0);
    chk("R3 one STOP seen", stops - p0, 1);
    chk("R13 bus released after stop", bus_owned, 0);
    chk("R13 sda high after stop", sda_line, 1);
  endtask

  task automatic t_slave_nak();
    ack_en = 1'b0;
    set_buf(8'h62);
    xfer(FS);
    chk("R9 slave nak reported", ack_ok, 0);
    ack_en = 1'b1;
    set_buf(8'h00);
    xfer(FP);
    chk("R13 released after nak stop", bus_owned, 0);
  endtask

  task automatic t_read();
    int p0;
    rd_byte = 8'hC7;
    set_buf(8'hA1);
    xfer(FS);
    chk("R4 receive after R/W=1", rx_mode, 1);
    set_buf(8'h00);
    xfer(4'h0);
    chk("R8 received byte in buffer", buf_rdata, 8'hC7);
    chk("R8 master ACK sent", mack, 0);
    set_buf(8'h00);
    p0 = stops;
    xfer(FP | FN);
    chk("R8 second byte received", buf_rdata, 8'hC7);
    chk("R8 master NAK sent", mack, 1);
    chk("R8 STOP after NAK", stops - p0, 1);
    chk("R6 nak bit kept", ctl_rdata[3], 1);
  endtask

  task automatic t_restart();
    int s0, p0;
    set_buf(8'hA0);
    xfer(FS);
    set_buf(8'h44);
    xfer(4'h0);
    s0 = starts; p0 = stops;
    set_buf(8'hA1);
    xfer(FS);
    chk("R5 repeated START", starts - s0, 1);
    chk("R5 no STOP between", stops - p0, 0);
    chk("R5 new address sent", addr_rx, 8'hA1);
    chk("R5 direction switched", rx_mode, 1);
    chk("R5 bus still owned", bus_owned, 1);
    xfer(FP | FN);
    chk("R8 read after restart", buf_rdata, 8'hC7);
  endtask

  task automatic t_busy_bus();
    force_low = 1'b1;
    set_buf(8'hA0);
    set_ctl(FS | FX);
    repeat (200) @(negedge clk);
    chk("R7 waiting while bus busy", ctl_rdata[0], 1);
    chk("R7 scl not driven while waiting", scl_lo, 0);
    chk("R7 sda not driven while waiting", sda_lo, 0);
    force_low = 1'b0;
    wait_idle();
    chk("R7 start after bus freed", addr_rx, 8'hA0);
    chk("R7 owned after retry", bus_owned, 1);
    set_buf(8'h00);
    xfer(FP);
  endtask

  task automatic t_arb_data();
    set_buf(8'hA0);
    xfer(FS);
    force_low = 1'b1;
    set_buf(8'h80);
    xfer(4'h0);
    chk("R10 arbitration lost flagged", arb_lost, 1);
    chk("R10 ownership dropped", bus_owned, 0);
    chk("R10 launch bit cleared", ctl_rdata[0], 0);
    chk("R10 scl released", scl_lo, 0);
    chk("R10 sda released", sda_lo, 0);
    force_low = 1'b0;
    repeat (20) @(negedge clk);
    set_buf(8'hA0);
    xfer(FS);
    chk("R10 flag cleared by next launch", arb_lost, 0);
    set_buf(8'h00);
    xfer(FP);
  endtask

  task automatic t_noop_unowned();
    int s0 = starts;
    set_buf(8'h11);
    xfer(4'h0);
    chk("R1 unowned bare byte is a no-op", starts - s0, 0);
    chk("R1 unowned bare byte completes", ctl_rdata[0], 0);
    chk("R13 lines released after no-op", scl_line, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_launch_addr();
    t_plain_write();
    t_write_stop();
    t_slave_nak();
    t_read();
    t_restart();
    t_busy_bus();
    t_arb_data();
    t_noop_unowned();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule